// File: doc/BRIEF.md
# Entropy Word Buffer with Mode Control

This block collects 64-bit random words into a 64-entry buffer and hands them to a host. A control register selects where each new word comes from. The first source is a raw sample packer that streams words from a group of ring oscillators. The second is an external conditioner, reached through a request/response port; it returns one hashed word per request after a fixed latency. The buffer keeps itself topped up: every time the host takes a word out, production resumes until all 64 slots are filled again.

The host asks for words with a single request that carries a length. One word models a plain load, and up to 32 words model a burst. The words come back in buffer order, one per cycle while the buffer has data. The response stalls while the buffer is empty, so the host never receives a stale word. A control write with the clear bit set disables the generator, drops every buffered word, cancels any burst in progress, and discards the reply to a conditioner request that was still in flight. A self-test status output always reads as zero.

Top module: `entropy_fifo`

## Requirements
- R1: `ctlRdData` returns the last written control value. The fields are generator enable (bit 0), entropy enable (bit 1), raw expose (bit 2) and oscillator group (bits 7:4). Every other bit reads 0, including the self-clearing clear bit (bit 8).
- R2: A control write with bit 8 set clears the whole register to 0, empties the buffer and cancels any pending host request. A conditioner reply still outstanding at that moment is discarded, and no new conditioner request is issued until that reply has arrived.
- R3: The buffer holds 64 words. When it is full, `rawReady` and `condReq` stay low.
- R4: The mode is decoded from the enable bits:
  - Generator enable clear: idle, with no `condReq` and no `rawReady`.
  - Generator enable set, entropy enable clear: deterministic. `condReq` is issued with `condUseEntropy` = 0, and raw expose is ignored.
  - Generator enable and entropy enable set, raw expose clear: conditioned. `condReq` is issued with `condUseEntropy` = 1.
  - All three set: raw. `rawReady` is offered and `condReq` is never raised.
- R5: At most one conditioner request is outstanding at a time. Each accepted reply word enters the buffer unchanged.
- R6: `oscGroup` equals control bits 7:4, and `oscEnable` is high exactly when generator and entropy enable are both set.
- R7: A request accepted while `reqReady` is high returns `reqLen`+1 words in buffer order on `dataValid`/`dataWord`, and `dataLast` marks the final one. `reqReady` stays low until the last word has been taken.
- R8: `dataValid` never rises while the buffer is empty. A waiting request resumes as soon as a word has been written.
- R9: After words are read out, production resumes until the buffer again holds 64 words.
- R10: A change of mode or group leaves buffered words in place. Only words produced after the write follow the new setting.
- R11: `selfTestStatus` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlWrData | input | 64 | Control write value |
| ctlRdData | output | 64 | Control register read value |
| selfTestStatus | output | 64 | Self-test result, constant zero |
| oscEnable | output | 1 | Enable for the ring oscillators |
| oscGroup | output | 4 | Selected oscillator group |
| rawValid | input | 1 | Packer word available |
| rawWord | input | 64 | Packer word |
| rawReady | output | 1 | Packer word accepted this cycle |
| condReq | output | 1 | Conditioner request, one cycle per word |
| condUseEntropy | output | 1 | 1: hash oscillator samples, 0: fixed inputs |
| condRspValid | input | 1 | Conditioner reply strobe |
| condWord | input | 64 | Conditioner reply word (first 64 hash bits) |
| reqValid | input | 1 | Host read request |
| reqLen | input | 5 | Words requested minus one |
| reqReady | output | 1 | Host request can be accepted |
| dataValid | output | 1 | Read word valid |
| dataWord | output | 64 | Read word |
| dataLast | output | 1 | Final word of the request |

## Verification
The hardest case to reach is a clear issued while a conditioner request is still in flight. The late reply must then be thrown away, and the next request must wait for it. The stimulus waits until `condReq` is seen and then issues the clear ten cycles into the conditioner latency. It re-enables deterministic mode and checks that the first word read out is the reply to the fresh request. A second hard case is a group change while the buffer is full. To cover it, the raw source tags every word with the group it was produced under. The bench then reads 64 words carrying the old tag, followed by words carrying the new one.

// File: rtl/entropy_pkg.sv
package entropy_pkg;

  typedef enum logic [1:0] {
    MODE_OFF,
    MODE_DET,
    MODE_COND,
    MODE_RAW
  } genMode_e;

  // strobes from the control module to the datapath
  typedef struct packed {
    logic clear;
    logic pushRaw;
    logic pushCond;
    logic pop;
    logic popLast;
  } dpStrobe_t;

  localparam int GEN_EN_POS  = 0;
  localparam int ENT_EN_POS  = 1;
  localparam int RAW_EXP_POS = 2;
  localparam int GROUP_LSB   = 4;

endpackage

// File: rtl/entropy_ctl.sv
module entropy_ctl
  import entropy_pkg::*;
#(
  parameter int CTL_W     = 64,
  parameter int GROUP_W   = 4,
  parameter int MAX_BURST = 32,
  localparam int LEN_W    = $clog2(MAX_BURST),
  localparam int REM_W    = $clog2(MAX_BURST + 1),
  localparam int CLR_POS  = GROUP_LSB + GROUP_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctlWrEn,
  input  logic [CTL_W-1:0]   ctlWrData,
  output logic [CTL_W-1:0]   ctlRdData,
  output logic               oscEnable,
  output logic [GROUP_W-1:0] oscGroup,
  input  logic               rawValid,
  output logic               rawReady,
  output logic               condReq,
  output logic               condUseEntropy,
  input  logic               condRspValid,
  input  logic               reqValid,
  input  logic [LEN_W-1:0]   reqLen,
  output logic               reqReady,
  input  logic               fifoFull,
  input  logic               fifoEmpty,
  output dpStrobe_t          stb
);

  logic               genEn, entEn, rawExp;
  logic [GROUP_W-1:0] group;
  logic               pending, stale;
  logic [REM_W-1:0]   remaining;
  genMode_e           mode;
  logic               clrNow, condMode, popNow;
  logic               unusedCtlBits;

  assign unusedCtlBits = ^{ctlWrData[CTL_W-1:CLR_POS+1],
                           ctlWrData[GROUP_LSB-1:RAW_EXP_POS+1]};
  assign clrNow = ctlWrEn && ctlWrData[CLR_POS];

  always_comb begin
    if (!genEn)       mode = MODE_OFF;
    else if (!entEn)  mode = MODE_DET;
    else if (!rawExp) mode = MODE_COND;
    else              mode = MODE_RAW;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genEn  <= 1'b0;
      entEn  <= 1'b0;
      rawExp <= 1'b0;
      group  <= '0;
    end else if (ctlWrEn) begin
      if (clrNow) begin
        genEn  <= 1'b0;
        entEn  <= 1'b0;
        rawExp <= 1'b0;
        group  <= '0;
      end else begin
        genEn  <= ctlWrData[GEN_EN_POS];
        entEn  <= ctlWrData[ENT_EN_POS];
        rawExp <= ctlWrData[RAW_EXP_POS];
        group  <= ctlWrData[GROUP_LSB +: GROUP_W];
      end
    end
  end

  always_comb begin
    ctlRdData                        = '0;
    ctlRdData[GEN_EN_POS]            = genEn;
    ctlRdData[ENT_EN_POS]            = entEn;
    ctlRdData[RAW_EXP_POS]           = rawExp;
    ctlRdData[GROUP_LSB +: GROUP_W]  = group;
  end

  assign oscEnable      = genEn && entEn;
  assign oscGroup       = group;
  assign condUseEntropy = entEn;

  // producer side
  assign condMode = (mode == MODE_DET) || (mode == MODE_COND);
  assign condReq  = condMode && !pending && !stale && !fifoFull;
  assign rawReady = (mode == MODE_RAW) && !pending && !stale && !fifoFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      stale   <= 1'b0;
    end else if (clrNow) begin
      pending <= 1'b0;
      stale   <= ((pending || stale) && !condRspValid) || condReq;
    end else begin
      if (condReq)           pending <= 1'b1;
      else if (condRspValid) pending <= 1'b0;
      if (condRspValid)      stale   <= 1'b0;
    end
  end

  // host side
  assign reqReady = (remaining == '0);
  assign popNow   = (remaining != '0) && !fifoEmpty && !clrNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      remaining <= '0;
    else if (clrNow)                remaining <= '0;
    else if (reqValid && reqReady)  remaining <= REM_W'(reqLen) + REM_W'(1);
    else if (popNow)                remaining <= remaining - REM_W'(1);
  end

  always_comb begin
    stb.clear    = clrNow;
    stb.pushRaw  = rawValid && rawReady && !clrNow;
    stb.pushCond = condRspValid && pending && !clrNow;
    stb.pop      = popNow;
    stb.popLast  = popNow && (remaining == REM_W'(1));
  end

  p_src_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(condReq && rawReady));

  p_single_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    condReq |=> !condReq);

  p_clear_ctl_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && ctlWrData[CLR_POS]) |=> (ctlRdData == '0) && reqReady);

  p_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !clrNow) |=> !reqReady);

endmodule

// File: rtl/entropy_dp.sv
module entropy_dp
  import entropy_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [WORD_W-1:0] rawWord,
  input  logic [WORD_W-1:0] condWord,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              dataValid,
  output logic [WORD_W-1:0] dataWord,
  output logic              dataLast
);

  logic [WORD_W-1:0] store [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [AW:0]       count;
  logic              pushNow;
  logic [WORD_W-1:0] pushWord;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pushNow   = stb.pushRaw || stb.pushCond;
  assign pushWord  = stb.pushRaw ? rawWord : condWord;
  assign fifoFull  = (count == (AW+1)'(DEPTH));
  assign fifoEmpty = (count == '0);

  always_ff @(posedge clk) begin
    if (pushNow) store[wrPtr] <= pushWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (stb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushNow)  wrPtr <= bump(wrPtr);
      if (stb.pop)  rdPtr <= bump(rdPtr);
      case ({pushNow, stb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataValid <= 1'b0;
      dataLast  <= 1'b0;
      dataWord  <= '0;
    end else begin
      dataValid <= stb.pop;
      dataLast  <= stb.popLast;
      if (stb.pop) dataWord <= store[rdPtr];
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    pushNow |-> !fifoFull);

  p_count_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    count <= (AW+1)'(DEPTH));

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> !fifoEmpty);

  p_one_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.pushRaw && stb.pushCond));

  p_clear_empties_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> fifoEmpty && !dataValid);

endmodule

// File: rtl/entropy_fifo.sv
module entropy_fifo
  import entropy_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int WORD_W    = 64,
  parameter int MAX_BURST = 32,
  parameter int GROUP_W   = 4,
  localparam int CTL_W    = 64,
  localparam int LEN_W    = $clog2(MAX_BURST)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctlWrEn,
  input  logic [CTL_W-1:0]   ctlWrData,
  output logic [CTL_W-1:0]   ctlRdData,
  output logic [CTL_W-1:0]   selfTestStatus,
  output logic               oscEnable,
  output logic [GROUP_W-1:0] oscGroup,
  input  logic               rawValid,
  input  logic [WORD_W-1:0]  rawWord,
  output logic               rawReady,
  output logic               condReq,
  output logic               condUseEntropy,
  input  logic               condRspValid,
  input  logic [WORD_W-1:0]  condWord,
  input  logic               reqValid,
  input  logic [LEN_W-1:0]   reqLen,
  output logic               reqReady,
  output logic               dataValid,
  output logic [WORD_W-1:0]  dataWord,
  output logic               dataLast
);

  dpStrobe_t stb;
  logic      fifoFull, fifoEmpty;

  assign selfTestStatus = '0;

  entropy_ctl #(
    .CTL_W(CTL_W), .GROUP_W(GROUP_W), .MAX_BURST(MAX_BURST)
  ) ctl_i (
    .clk(clk), .rstN(rstN),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .ctlRdData(ctlRdData),
    .oscEnable(oscEnable), .oscGroup(oscGroup),
    .rawValid(rawValid), .rawReady(rawReady),
    .condReq(condReq), .condUseEntropy(condUseEntropy),
    .condRspValid(condRspValid),
    .reqValid(reqValid), .reqLen(reqLen), .reqReady(reqReady),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .stb(stb)
  );

  entropy_dp #(
    .DEPTH(DEPTH), .WORD_W(WORD_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rawWord(rawWord), .condWord(condWord),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .dataValid(dataValid), .dataWord(dataWord), .dataLast(dataLast)
  );

endmodule

// File: tb/entropy_fifo_tb_top.sv
module entropy_fifo_tb_top;

  localparam int COND_LAT = 81;
  localparam int DEPTH    = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWrEn = 1'b0;
  logic [63:0] ctlWrData = '0;
  logic [63:0] ctlRdData, selfTestStatus;
  logic        oscEnable;
  logic [3:0]  oscGroup;
  logic        rawValid = 1'b0;
  logic [63:0] rawWord = '0;
  logic        rawReady, condReq, condUseEntropy;
  logic        condRspValid = 1'b0;
  logic [63:0] condWord = '0;
  logic        reqValid = 1'b0;
  logic [4:0]  reqLen = '0;
  logic        reqReady, dataValid, dataLast;
  logic [63:0] dataWord;

  int nChecks = 0;
  int nFail = 0;
  logic [63:0] expQ[$];
  bit  condBusy = 0;
  bit  dropNext = 0;
  int  reqViol = 0;
  int  condIdx = 0;

  always #2 clk = ~clk;

  entropy_fifo dut_i (
    .clk(clk), .rstN(rstN),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .ctlRdData(ctlRdData),
    .selfTestStatus(selfTestStatus),
    .oscEnable(oscEnable), .oscGroup(oscGroup),
    .rawValid(rawValid), .rawWord(rawWord), .rawReady(rawReady),
    .condReq(condReq), .condUseEntropy(condUseEntropy),
    .condRspValid(condRspValid), .condWord(condWord),
    .reqValid(reqValid), .reqLen(reqLen), .reqReady(reqReady),
    .dataValid(dataValid), .dataWord(dataWord), .dataLast(dataLast)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // raw sample packer model: word tagged with the group it was made under
  initial begin : rawSource
    bit sawReady;
    int seq;
    sawReady = 0;
    seq = 0;
    @(posedge rstN);
    forever begin
      @(negedge clk);
      if (sawReady) seq++;
      rawWord  = {oscGroup, 28'h0, seq[31:0]};
      rawValid = 1'b1;
      sawReady = rawReady;
      if (rawReady) expQ.push_back(rawWord);
    end
  end

  // conditioner model: fixed latency, tag D = fixed inputs, C = entropy
  initial begin : condModel
    bit ue;
    forever begin
      @(negedge clk);
      while (condReq === 1'b1) begin
        ue = condUseEntropy;
        condBusy = 1;
        repeat (COND_LAT) begin
          @(negedge clk);
          if (condReq) reqViol++;
        end
        condWord = {ue ? 4'hC : 4'hD, 28'h0, 32'(condIdx)};
        condIdx++;
        condRspValid = 1'b1;
        if (dropNext) dropNext = 0;
        else expQ.push_back(condWord);
        @(negedge clk);
        condRspValid = 1'b0;
        condBusy = 0;
      end
    end
  end

  task automatic ctlWrite(input logic [63:0] v);
    ctlWrEn = 1'b1;
    ctlWrData = v;
    if (v[8]) dropNext = condBusy || condReq;
    @(negedge clk);
    ctlWrEn = 1'b0;
    if (v[8]) expQ.delete();
  endtask

  task automatic readWords(input int n, input int tagChk, input string tag,
                           output int cycles);
    int got;
    got = 0;
    cycles = 0;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    reqLen = 5'(n - 1);
    @(negedge clk);
    reqValid = 1'b0;
    while (got < n && cycles < 3000) begin
      if (dataValid) begin
        logic [63:0] e;
        e = (expQ.size() > 0) ? expQ.pop_front() : '1;
        chk(dataWord == e, {tag, " word order"}, dataWord, e);
        chk(dataLast == (got == n - 1), "R7 last flag", 64'(dataLast),
            64'(got == n - 1));
        if (tagChk >= 0)
          chk(dataWord[63:60] == 4'(tagChk), {tag, " tag"}, 64'(dataWord[63:60]),
              64'(tagChk));
        got++;
      end
      if (got < n) begin
        @(negedge clk);
        cycles++;
      end
    end
    chk(got == n, {tag, " burst length"}, 64'(got), 64'(n));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin : mainSeq
    int cyc;
    bit seen;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    chk(ctlRdData == 64'h0, "R1 reset ctl", ctlRdData, 64'h0);
    chk(reqReady == 1'b1, "R7 reset ready", 64'(reqReady), 64'h1);
    chk(dataValid == 1'b0, "R8 reset valid", 64'(dataValid), 64'h0);
    chk(!rawReady && !condReq, "R4 idle mode", {rawReady, condReq}, 64'h0);
    chk(selfTestStatus == 64'h0, "R11 self test", selfTestStatus, 64'h0);
    chk(oscEnable == 1'b0, "R6 osc off", 64'(oscEnable), 64'h0);

    // readback with spare bits written: raw mode, group 5
    ctlWrite(64'h0000_0100_0000_005F);
    chk(ctlRdData == 64'h57, "R1 readback", ctlRdData, 64'h57);
    chk(oscGroup == 4'd5 && oscEnable, "R6 group out", {oscEnable, oscGroup},
        64'h15);

    // fill to capacity
    repeat (120) @(negedge clk);
    chk(expQ.size() == DEPTH, "R3 capacity", 64'(expQ.size()), 64'(DEPTH));
    chk(rawReady == 1'b0, "R3 full stall", 64'(rawReady), 64'h0);
    chk(condReq == 1'b0, "R4 raw no cond", 64'(condReq), 64'h0);

    // every burst length
    for (int n = 1; n <= 32; n++) readWords(n, 5, "R7", cyc);
    repeat (100) @(negedge clk);
    chk(expQ.size() == DEPTH, "R9 refill", 64'(expQ.size()), 64'(DEPTH));
    chk(rawReady == 1'b0, "R9 full again", 64'(rawReady), 64'h0);

    // group change with a full buffer
    ctlWrite(64'h97);
    repeat (3) @(negedge clk);
    chk(oscGroup == 4'd9, "R6 new group", 64'(oscGroup), 64'h9);
    readWords(32, 5, "R10", cyc);
    readWords(32, 5, "R10", cyc);
    readWords(8, 9, "R10", cyc);

    // clear: register zero, buffer empty
    ctlWrite(64'h197);
    chk(ctlRdData == 64'h0, "R2 clear ctl", ctlRdData, 64'h0);
    chk(rawReady == 1'b0, "R2 disabled", 64'(rawReady), 64'h0);
    reqValid = 1'b1;
    reqLen = 5'd0;
    @(negedge clk);
    reqValid = 1'b0;
    seen = 0;
    repeat (30) begin
      if (dataValid) seen = 1;
      @(negedge clk);
    end
    chk(!seen, "R2 buffer emptied", 64'(seen), 64'h0);
    chk(reqReady == 1'b0, "R8 read waiting", 64'(reqReady), 64'h0);

    // deterministic mode serves the waiting read
    ctlWrite(64'h01);
    chk(condReq && !condUseEntropy, "R4 deterministic req",
        {condReq, condUseEntropy}, 64'h2);
    cyc = 0;
    while (!dataValid && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
    chk(dataValid == 1'b1, "R8 resumed", 64'(dataValid), 64'h1);
    chk(cyc >= COND_LAT, "R8 no early data", 64'(cyc), 64'(COND_LAT));
    begin
      logic [63:0] e;
      e = (expQ.size() > 0) ? expQ.pop_front() : '1;
      chk(dataWord == e, "R5 cond word", dataWord, e);
    end
    chk(dataWord[63:60] == 4'hD, "R4 det tag", 64'(dataWord[63:60]), 64'hD);

    // conditioned mode
    ctlWrite(64'h100);
    ctlWrite(64'h03);
    while (!condReq) @(negedge clk);
    chk(condUseEntropy && !rawReady, "R4 conditioned req",
        {condUseEntropy, rawReady}, 64'h2);
    readWords(3, 12, "R4", cyc);

    // clear while a request is in flight
    ctlWrite(64'h100);
    ctlWrite(64'h01);
    while (!condReq) @(negedge clk);
    repeat (10) @(negedge clk);
    ctlWrite(64'h101);
    ctlWrite(64'h01);
    chk(condReq == 1'b0, "R2 stale blocks req", 64'(condReq), 64'h0);
    readWords(1, 13, "R2", cyc);

    // raw expose without entropy enable stays deterministic
    ctlWrite(64'h100);
    ctlWrite(64'h05);
    while (!condReq) @(negedge clk);
    chk(!rawReady && !condUseEntropy, "R4 raw ignored",
        {rawReady, condUseEntropy}, 64'h0);
    chk(reqViol == 0, "R5 one outstanding", 64'(reqViol), 64'h0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule